// File: doc/BRIEF.md
# Multicycle Issue Hazard Gate

This block sits in the decode stage of an in-order pipeline with five execution unit classes: an integer ALU, a load/store unit, a pipelined FP adder, a pipelined FP/integer multiplier and an unpipelined divider. For each decoded instruction it receives the unit class, an optional destination register and up to two optional source registers. It raises `stall` to hold the instruction in decode when a source would not yet be forwardable, when the destination still has an earlier write in flight, or when the divider is occupied.

A combined register space of 64 entries is tracked. Index bit 5 selects the FP file, and bits 4:0 select the register within that file. Each entry has a busy flag and a down-counter. When an instruction that writes the entry issues, the counter is loaded with that unit's extra latency. The counter then decrements every cycle. While the entry is busy and the counter is nonzero, the value cannot be forwarded. In the cycle after the counter reaches zero, the write completes and the busy flag clears. A separate counter blocks the divider for its full initiation interval.

The block drives `issue` when the decoded instruction leaves decode. Upstream logic keeps the decode register unchanged while `stall` is high.

Top module: `issue_hazard_gate`

## Requirements
- R1: While `rst_n` is low at a rising edge, all busy flags, all counters and the divider occupancy are cleared. After reset, no instruction stalls.
- R2: Unit codes are 0 ALU, 1 load/store, 2 FP add, 3 multiply and 4 divide, with extra latencies 0, 1, 3, 6 and 24. Codes 5 to 7 behave as ALU. An instruction that reads the destination of an instruction issued in the previous cycle stalls exactly that producer's latency in cycles.
- R3: Once a busy register's counter is zero, a reader issues without stalling. An ALU result is therefore readable back-to-back.
- R4: An instruction whose destination is busy stalls until the earlier write completes. After a producer of latency L, this is L+1 cycles.
- R5: After a divide issues, another divide stalls for 24 cycles. This gives 25 cycles from issue to issue.
- R6: A non-divide instruction with no register conflict issues while the divider is occupied.
- R7: Index 0 (integer register 0) is never marked busy and never causes a stall. Index 32 (FP register 0) is tracked like any other register.
- R8: A stalled instruction changes no busy flag. Its destination stays free once it is withdrawn.
- R9: With `dec_valid` low, `stall` and `issue` are low and nothing is recorded.
- R10: A source or destination whose enable is low takes no part in hazard checks. A destination whose enable is low is not recorded.
- R11: `issue` equals `dec_valid` with `stall` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_unit | input | 3 | Execution unit class code |
| dec_dst | input | 6 | Destination index (bit 5 = FP file) |
| dec_dst_en | input | 1 | Instruction writes a destination |
| dec_src_a | input | 6 | First source index |
| dec_src_a_en | input | 1 | First source is read |
| dec_src_b | input | 6 | Second source index |
| dec_src_b_en | input | 1 | Second source is read |
| stall | output | 1 | Hold the instruction in decode |
| issue | output | 1 | Instruction leaves decode this cycle |

## Verification
The assertions assume that the index and unit inputs are stable during each cycle. They also assume that a stalled instruction may be withdrawn or replaced. They do not require it to be held. The properties check only what follows from an actual issue or a non-issue. The stimulus drives inputs half a cycle away from the sampling edge. It holds an instruction while it stalls, except in the directed case that withdraws one on purpose. Random indices are drawn from a small set in both files, including both register 0 entries, so that RAW, WAW and divider conflicts occur often.

// File: rtl/hz_pkg.sv
// Shared definitions for the issue hazard gate.
// Assumes: unit codes above FDIV are treated as ALU by the consumers.
package hz_pkg;
    typedef enum logic [2:0] {
        UNIT_ALU  = 3'd0,
        UNIT_MEM  = 3'd1,
        UNIT_FADD = 3'd2,
        UNIT_FMUL = 3'd3,
        UNIT_FDIV = 3'd4
    } unit_e;
endpackage

// File: rtl/hz_scoreboard.sv
// Per-register busy flags with forwarding countdown.
// Assumes: a set request never targets an entry that is already busy
// (the hazard logic guarantees this); set wins over countdown.
module hz_scoreboard #(
    parameter int NREG  = 64,
    parameter int IDX_W = 6,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [CNT_W-1:0] set_lat,
    output logic [NREG-1:0]  busy,
    output logic [NREG-1:0]  fwd_ok
);
    for (genvar r = 0; r < NREG; r++) begin : g_entry
        logic [CNT_W-1:0] cnt_q;
        logic             busy_q;

        // Load on issue, count down while busy, free one cycle after zero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else if (set_en && (set_idx == IDX_W'(r))) begin
                busy_q <= 1'b1;
                cnt_q  <= set_lat;
            end else if (busy_q) begin
                if (cnt_q == '0) busy_q <= 1'b0;
                else             cnt_q  <= cnt_q - 1'b1;
            end
        end

        assign busy[r]   = busy_q;
        assign fwd_ok[r] = (cnt_q == '0);
    end
endmodule

// File: rtl/hz_div_tracker.sv
// Tracks occupancy of the unpipelined divider.
// Assumes: start is only raised when occupied is low.
module hz_div_tracker #(
    parameter int II = 25,
    parameter int CW = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic occupied
);
    logic [CW-1:0] left_q;

    // Reload to II-1 on start, then count down to free.
    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (start)          left_q <= CW'(II - 1);
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign occupied = (left_q != '0);
endmodule

// File: rtl/hz_detect.sv
// Combinational stall decision from scoreboard and divider state.
// Assumes: index 0 is the hard-wired integer zero register.
module hz_detect #(
    parameter int NREG  = 64,
    parameter int IDX_W = 6
) (
    input  logic             valid,
    input  logic             is_div,
    input  logic [IDX_W-1:0] dst,
    input  logic             dst_en,
    input  logic [IDX_W-1:0] src_a,
    input  logic             src_a_en,
    input  logic [IDX_W-1:0] src_b,
    input  logic             src_b_en,
    input  logic [NREG-1:0]  busy,
    input  logic [NREG-1:0]  fwd_ok,
    input  logic             div_occupied,
    output logic             stall
);
    logic raw_a, raw_b, waw, div_hold;

    // Evaluate each hazard reason and combine them.
    always_comb begin
        raw_a    = src_a_en && (src_a != '0) && busy[src_a] && !fwd_ok[src_a];
        raw_b    = src_b_en && (src_b != '0) && busy[src_b] && !fwd_ok[src_b];
        waw      = dst_en && (dst != '0) && busy[dst];
        div_hold = is_div && div_occupied;
        stall    = valid && (raw_a || raw_b || waw || div_hold);
    end
endmodule

// File: rtl/issue_hazard_gate.sv
// Decode-stage issue gate for an in-order multi-latency pipeline.
// Assumes: upstream holds the decode slot while stall is high.
module issue_hazard_gate #(
    parameter int NREG_FILE = 32,
    parameter int LAT_ALU   = 0,
    parameter int LAT_MEM   = 1,
    parameter int LAT_FADD  = 3,
    parameter int LAT_FMUL  = 6,
    parameter int LAT_FDIV  = 24,
    parameter int DIV_II    = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dec_valid,
    input  logic [2:0] dec_unit,
    input  logic [5:0] dec_dst,
    input  logic       dec_dst_en,
    input  logic [5:0] dec_src_a,
    input  logic       dec_src_a_en,
    input  logic [5:0] dec_src_b,
    input  logic       dec_src_b_en,
    output logic       stall,
    output logic       issue
);
    import hz_pkg::*;

    localparam int NREG  = 2 * NREG_FILE;
    localparam int IDX_W = $clog2(NREG);
    localparam int CNT_W = $clog2(LAT_FDIV + 1);
    localparam int DIV_W = $clog2(DIV_II);

    logic [NREG-1:0]  busy, fwd_ok;
    logic [CNT_W-1:0] lat;
    logic             is_div, div_busy, sb_set;

    // Pick the extra latency of the decoded unit.
    always_comb begin
        case (dec_unit)
            UNIT_MEM:  lat = CNT_W'(LAT_MEM);
            UNIT_FADD: lat = CNT_W'(LAT_FADD);
            UNIT_FMUL: lat = CNT_W'(LAT_FMUL);
            UNIT_FDIV: lat = CNT_W'(LAT_FDIV);
            default:   lat = CNT_W'(LAT_ALU);
        endcase
    end

    assign is_div = (dec_unit == UNIT_FDIV);
    assign issue  = dec_valid && !stall;
    assign sb_set = issue && dec_dst_en && (dec_dst != '0);

    hz_scoreboard #(.NREG(NREG), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_sb (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (sb_set),
        .set_idx(dec_dst),
        .set_lat(lat),
        .busy   (busy),
        .fwd_ok (fwd_ok)
    );

    hz_div_tracker #(.II(DIV_II), .CW(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (issue && is_div),
        .occupied(div_busy)
    );

    hz_detect #(.NREG(NREG), .IDX_W(IDX_W)) u_det (
        .valid       (dec_valid),
        .is_div      (is_div),
        .dst         (dec_dst),
        .dst_en      (dec_dst_en),
        .src_a       (dec_src_a),
        .src_a_en    (dec_src_a_en),
        .src_b       (dec_src_b),
        .src_b_en    (dec_src_b_en),
        .busy        (busy),
        .fwd_ok      (fwd_ok),
        .div_occupied(div_busy),
        .stall       (stall)
    );
endmodule

// File: rtl/issue_hazard_gate_chk.sv
// Property checker for issue_hazard_gate, attached by bind.
// Assumes: observes ports plus scoreboard and divider state.
module issue_hazard_gate_chk #(
    parameter int NREG = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dec_valid,
    input logic [2:0]      dec_unit,
    input logic [5:0]      dec_dst,
    input logic            dec_dst_en,
    input logic [5:0]      dec_src_a,
    input logic            dec_src_a_en,
    input logic [5:0]      dec_src_b,
    input logic            dec_src_b_en,
    input logic            stall,
    input logic            issue,
    input logic [NREG-1:0] busy,
    input logic [NREG-1:0] fwd_ok,
    input logic            div_busy
);
    assert_zero_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy[0]);

    assert_issue_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_dst_en && dec_dst != 6'd0) |=> busy[$past(dec_dst)]);

    assert_noissue_nomark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> ((busy & ~$past(busy)) == '0));

    assert_div_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_unit == 3'd4 && div_busy) |-> stall);

    assert_div_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_unit == 3'd4) |=> div_busy);

    assert_raw_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_src_a_en && dec_src_a != 6'd0) |-> (!busy[dec_src_a] || fwd_ok[dec_src_a]));

    assert_raw_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_src_b_en && dec_src_b != 6'd0) |-> (!busy[dec_src_b] || fwd_ok[dec_src_b]));

    assert_waw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_dst_en && dec_dst != 6'd0) |-> !busy[dec_dst]);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!stall && !issue));
endmodule

bind issue_hazard_gate issue_hazard_gate_chk #(.NREG(NREG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_valid   (dec_valid),
    .dec_unit    (dec_unit),
    .dec_dst     (dec_dst),
    .dec_dst_en  (dec_dst_en),
    .dec_src_a   (dec_src_a),
    .dec_src_a_en(dec_src_a_en),
    .dec_src_b   (dec_src_b),
    .dec_src_b_en(dec_src_b_en),
    .stall       (stall),
    .issue       (issue),
    .busy        (busy),
    .fwd_ok      (fwd_ok),
    .div_busy    (div_busy)
);

// File: tb/issue_hazard_gate_tb.sv
// Self-checking bench: random instruction stream plus directed corners,
// compared every cycle against a requirement-level scoreboard model.
module issue_hazard_gate_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_valid = 1'b0;
    logic [2:0] dec_unit = '0;
    logic [5:0] dec_dst = '0, dec_src_a = '0, dec_src_b = '0;
    logic       dec_dst_en = 1'b0, dec_src_a_en = 1'b0, dec_src_b_en = 1'b0;
    logic       stall, issue;

    int n_chk = 0, n_bad = 0;
    bit m_busy [64];
    int m_cnt  [64];
    int m_div;
    bit last_stall;

    always #4 clk = ~clk;  // 125 MHz

    issue_hazard_gate u_dut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_unit(dec_unit),
        .dec_dst(dec_dst), .dec_dst_en(dec_dst_en),
        .dec_src_a(dec_src_a), .dec_src_a_en(dec_src_a_en),
        .dec_src_b(dec_src_b), .dec_src_b_en(dec_src_b_en),
        .stall(stall), .issue(issue)
    );

    function automatic int lat_of(input logic [2:0] u);
        case (u)
            3'd1: return 1;
            3'd2: return 3;
            3'd3: return 6;
            3'd4: return 24;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_stall();
        bit s = 0;
        if (!dec_valid) return 0;
        if (dec_src_a_en && dec_src_a != 0 && m_busy[dec_src_a] && m_cnt[dec_src_a] != 0) s = 1;
        if (dec_src_b_en && dec_src_b != 0 && m_busy[dec_src_b] && m_cnt[dec_src_b] != 0) s = 1;
        if (dec_dst_en && dec_dst != 0 && m_busy[dec_dst]) s = 1;
        if (dec_unit == 3'd4 && m_div != 0) s = 1;
        return s;
    endfunction

    task automatic model_clear();
        for (int r = 0; r < 64; r++) begin m_busy[r] = 0; m_cnt[r] = 0; end
        m_div = 0;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: inputs already driven after a falling edge.
    task automatic run_op(input string tag);
        bit es;
        #2;
        es = exp_stall();
        check({tag, " stall"}, stall, es);
        check("R11 issue", issue, dec_valid && !es);
        last_stall = es;
        for (int r = 0; r < 64; r++)
            if (m_busy[r]) begin
                if (m_cnt[r] == 0) m_busy[r] = 0; else m_cnt[r]--;
            end
        if (m_div > 0) m_div--;
        if (dec_valid && !es) begin
            if (dec_dst_en && dec_dst != 0) begin
                m_busy[dec_dst] = 1; m_cnt[dec_dst] = lat_of(dec_unit);
            end
            if (dec_unit == 3'd4) m_div = 24;
        end
        @(negedge clk);
    endtask

    task automatic put(input bit v, input int u, input int d, input bit de,
                       input int a, input bit ae, input int b, input bit be);
        dec_valid = v; dec_unit = 3'(u); dec_dst = 6'(d); dec_dst_en = de;
        dec_src_a = 6'(a); dec_src_a_en = ae; dec_src_b = 6'(b); dec_src_b_en = be;
    endtask

    task automatic drain();
        put(0, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 30; i++) run_op("R9 drain");
    endtask

    // Present the current op until it issues; return stall cycles seen.
    task automatic until_issue(input string tag, output int n);
        n = 0;
        run_op(tag);
        while (last_stall && n < 40) begin n++; run_op(tag); end
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'h5eed_1234));
        model_clear();
        @(negedge clk);
        put(1, 4, 3, 1, 3, 1, 3, 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_op("R1 after reset");

        // Latency of each unit class as seen by a dependent reader (R2, R3).
        for (int u = 0; u < 8; u++) begin
            drain();
            put(1, u, 5, 1, 0, 0, 0, 0); run_op("R2 producer");
            put(1, 0, 6, 1, 5, 1, 0, 0); until_issue("R2 reader", n);
            check(u == 0 ? "R3 back-to-back" : "R2 raw stalls", n, lat_of(3'(u)));
            drain();
            put(1, u, 7, 1, 0, 0, 0, 0); run_op("R4 producer");
            put(1, 0, 7, 1, 0, 0, 0, 0); until_issue("R4 waw", n);
            check("R4 waw stalls", n, lat_of(3'(u)) + 1);
        end

        // Divider interval and independent traffic (R5, R6).
        drain();
        put(1, 4, 8, 1, 0, 0, 0, 0); run_op("R5 div1");
        put(1, 2, 10, 1, 1, 1, 2, 1); until_issue("R6 indep", n);
        check("R6 indep during div", n, 0);
        put(1, 4, 9, 1, 0, 0, 0, 0); until_issue("R5 div2", n);
        check("R5 div stalls", n, 23);

        // Register 0 and FP register 0 (R7).
        drain();
        put(1, 3, 0, 1, 0, 0, 0, 0); run_op("R7 zero write");
        put(1, 0, 1, 1, 0, 1, 0, 1); until_issue("R7 zero read", n);
        check("R7 int0 never busy", n, 0);
        drain();
        put(1, 3, 32, 1, 0, 0, 0, 0); run_op("R7 fp0 write");
        put(1, 0, 1, 1, 32, 1, 0, 0); until_issue("R7 fp0 read", n);
        check("R7 fp0 tracked", n, 6);

        // Stalled op withdrawn leaves its destination free (R8).
        drain();
        put(1, 4, 8, 1, 0, 0, 0, 0); run_op("R8 div");
        put(1, 4, 11, 1, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) run_op("R8 held");
        put(1, 0, 12, 1, 11, 1, 11, 1); until_issue("R8 reader", n);
        check("R8 no mark on stall", n, 0);

        // Invalid slot and disabled fields (R9, R10).
        drain();
        put(0, 3, 13, 1, 0, 0, 0, 0); run_op("R9 invalid");
        put(1, 0, 13, 1, 13, 1, 0, 0); until_issue("R9 after invalid", n);
        check("R9 nothing recorded", n, 0);
        drain();
        put(1, 3, 14, 1, 0, 0, 0, 0); run_op("R10 producer");
        put(1, 0, 14, 0, 14, 0, 14, 0); until_issue("R10 disabled", n);
        check("R10 enables off", n, 0);
        put(1, 3, 15, 0, 0, 0, 0, 0); run_op("R10 no dst");
        put(1, 0, 1, 1, 15, 1, 0, 0); until_issue("R10 reader", n);
        check("R10 dst not recorded", n, 0);

        // Random stream with in-order hold (R2, R4, R5).
        last_stall = 0;
        for (int i = 0; i < 4000; i++) begin
            if (!last_stall) begin
                int pick [8] = '{0, 1, 2, 3, 32, 33, 34, 35};
                put(($urandom % 8) != 0, $urandom % 8, pick[$urandom % 8], ($urandom % 5) != 0,
                    pick[$urandom % 8], ($urandom % 3) != 0, pick[$urandom % 8], ($urandom % 2) != 0);
            end
            if (i == 2000) begin
                rst_n = 1'b0; model_clear(); last_stall = 0;
                @(negedge clk);
                rst_n = 1'b1;
                run_op("R1 mid reset");
            end else begin
                run_op("R2 random");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule